// File: doc/BRIEF.md
# CRC Error Counter Setup and Readback Sequencer

This block is a small bus master that sets up a remote event counter to tally CRC errors and then fetches the 32-bit tally. A one-cycle `start` begins the run. The block then goes through a fixed chain of configuration steps. Each step reads a control byte and writes it back with only the step's own field changed. It does this for the CRC check enable, the counter group, the event code, the lane select and the counter enable, in that order. After the chain, it reads the four count bytes and returns the assembled word with a one-cycle `done`.

The `e2e_mode` input picks which tally is set up: 0 for the link-level CRC tally, 1 for the end-to-end CRC tally. It is sampled in the cycle `start` is accepted. The `PORT_MAP` parameter picks where the remote control window sits. Value 0 puts it at 0x340, value 1 at 0x308 and value 2 at 0x2B4. The CRC enable byte is at 0x119 for every map.

The bus side follows the usual memory-mapped master rules. `mm_read` or `mm_write` stays asserted, with address and write data held steady, while the slave raises `mm_waitreq`. A command is accepted on the first clock edge where `mm_waitreq` is low. Read data can come back any number of cycles later and is taken only when `mm_rvalid` is high. At most one read is outstanding.

Top module: `crc_errcnt_sequencer`

## Requirements
- R1: A `start` seen while idle makes `busy` high on the next cycle. In that same cycle the first command is a read of address 0x119.
- R2: The configuration steps use these addresses, in this order: 0x119, then base+3 (group), base+2 (event), base+1 (lane), base+0 (counter enable). The base is 0x340, 0x308 or 0x2B4 for `PORT_MAP` 0, 1 or 2.
- R3: Every configuration step reads its address and then writes that same address. A write always follows a returned read. `mm_read` and `mm_write` are never both high.
- R4: The write-back changes only the step's own field. CRC enable sets bit 0 and keeps bits [7:1]. Group, event and lane replace the whole byte. Counter enable writes bits [4:0] as 5'b11100, so bits [4:2] are set, the clear field [1:0] is zero, and bits [7:5] are kept.
- R5: With `e2e_mode`=0 the group code is 8'h02 and the event code is 8'h01. With `e2e_mode`=1 they are 8'h03 and 8'h02. The lane code is 8'h00 in both modes. The mode is latched when `start` is accepted.
- R6: A command stays asserted, with address and write data unchanged, for every cycle that `mm_waitreq` is high. The next command is issued with no idle gap.
- R7: `mm_rdata` is taken only when `mm_rvalid` is high while a read is outstanding. `mm_rvalid` pulses at any other time have no effect on the data written or the count.
- R8: The count is read from base+4 up to base+7. The byte at base+4+k becomes bits [8k+7:8k] of `err_count`.
- R9: `done` is a one-cycle pulse in the cycle after the last count byte is returned. `busy` is low in that cycle. `err_count` takes its new value in that cycle and keeps it until the next completion.
- R10: A `start` pulse while `busy` is high is ignored. The run in progress is neither restarted nor re-moded.
- R11: During reset and right after it: no command is issued, and `busy`, `done` and `err_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (only while idle) |
| e2e_mode | input | 1 | 0: link CRC tally, 1: end-to-end CRC tally |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err_count | output | 32 | Last assembled error count |
| mm_addr | output | 21 | Command address |
| mm_read | output | 1 | Read command |
| mm_write | output | 1 | Write command |
| mm_wdata | output | 8 | Write data |
| mm_rdata | input | 8 | Read return data |
| mm_waitreq | input | 1 | Slave stall; the command is held while high |
| mm_rvalid | input | 1 | Read return data valid |

## Verification
The bench builds three copies of the block, one for each `PORT_MAP` value (0, 1 and 2). This covers all three window bases and shows that the CRC enable address stays the same in every map. Each copy runs both modes against stall patterns ranging from none to four stalled cycles out of five. Read latencies range from one to three cycles, and stray `mm_rvalid` pulses are injected. This exercises command holding and the ignoring of returns outside a read. One run preloads bytes with bits set outside the target fields, which exposes any write-back that touches neighbouring bits.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;
  localparam int ADDR_W    = 21;
  localparam int DATA_W    = 8;
  localparam int CNT_BYTES = 4;
  localparam int CNT_W     = CNT_BYTES * DATA_W;
  localparam int CFG_STEPS = 5;
  localparam int STEPS     = CFG_STEPS + CNT_BYTES;
  localparam int STEP_W    = $clog2(STEPS);
  localparam int SEL_W     = $clog2(CNT_BYTES);

  localparam logic [ADDR_W-1:0] CRC_EN_ADDR = 21'h00119;

  localparam logic [DATA_W-1:0] GRP_LINK = 8'h02;
  localparam logic [DATA_W-1:0] GRP_E2E  = 8'h03;
  localparam logic [DATA_W-1:0] EVT_LINK = 8'h01;
  localparam logic [DATA_W-1:0] EVT_E2E  = 8'h02;
  localparam logic [DATA_W-1:0] LANE_ALL = 8'h00;
  localparam logic [DATA_W-1:0] ENA_MASK = 8'h1F;
  localparam logic [DATA_W-1:0] ENA_VAL  = 8'h1C;
  localparam logic [DATA_W-1:0] CRC_MASK = 8'h01;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RD_REQ,
    SEQ_RD_WAIT,
    SEQ_WR_REQ
  } seq_state_e;
endpackage

// File: rtl/errcnt_step_table.sv
module errcnt_step_table
  import errcnt_pkg::*;
#(
  parameter int PORT_MAP = 0
) (
  input  logic [STEP_W-1:0] step,
  input  logic              e2e,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] val,
  output logic              is_cfg,
  output logic              is_last
);
  logic [ADDR_W-1:0] base;

  generate
    if (PORT_MAP == 0) begin : g_wide
      assign base = 21'h00340;
    end else if (PORT_MAP == 1) begin : g_mid
      assign base = 21'h00308;
    end else begin : g_narrow
      assign base = 21'h002B4;
    end
  endgenerate

  always_comb begin
    addr    = base;
    mask    = '0;
    val     = '0;
    is_cfg  = (step < STEP_W'(CFG_STEPS));
    is_last = (step == STEP_W'(STEPS - 1));
    case (step)
      STEP_W'(0): begin
        addr = CRC_EN_ADDR;
        mask = CRC_MASK;
        val  = CRC_MASK;
      end
      STEP_W'(1): begin
        addr = base + ADDR_W'(3);
        mask = '1;
        val  = e2e ? GRP_E2E : GRP_LINK;
      end
      STEP_W'(2): begin
        addr = base + ADDR_W'(2);
        mask = '1;
        val  = e2e ? EVT_E2E : EVT_LINK;
      end
      STEP_W'(3): begin
        addr = base + ADDR_W'(1);
        mask = '1;
        val  = LANE_ALL;
      end
      STEP_W'(4): begin
        addr = base;
        mask = ENA_MASK;
        val  = ENA_VAL;
      end
      default: begin
        addr = base + ADDR_W'(CNT_BYTES) + ADDR_W'(step) - ADDR_W'(CFG_STEPS);
      end
    endcase
  end
endmodule

// File: rtl/errcnt_seq_ctrl.sv
module errcnt_seq_ctrl
  import errcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              e2e_mode,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] val,
  input  logic              is_cfg,
  input  logic              is_last,
  input  logic [DATA_W-1:0] mm_rdata,
  input  logic              mm_waitreq,
  input  logic              mm_rvalid,
  output logic [STEP_W-1:0] step,
  output logic              mode_q,
  output logic              busy,
  output logic              mm_read,
  output logic              mm_write,
  output logic [DATA_W-1:0] mm_wdata,
  output logic              cap_en,
  output logic [SEL_W-1:0]  byte_sel,
  output logic              commit
);
  seq_state_e        state;
  logic [STEP_W-1:0] rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      step     <= '0;
      mode_q   <= 1'b0;
      mm_wdata <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (start) begin
          step   <= '0;
          mode_q <= e2e_mode;
          state  <= SEQ_RD_REQ;
        end
        SEQ_RD_REQ: if (!mm_waitreq) state <= SEQ_RD_WAIT;
        SEQ_RD_WAIT: if (mm_rvalid) begin
          if (is_cfg) begin
            mm_wdata <= (mm_rdata & ~mask) | (val & mask);
            state    <= SEQ_WR_REQ;
          end else if (is_last) begin
            state <= SEQ_IDLE;
          end else begin
            step  <= step + STEP_W'(1);
            state <= SEQ_RD_REQ;
          end
        end
        SEQ_WR_REQ: if (!mm_waitreq) begin
          step  <= step + STEP_W'(1);
          state <= SEQ_RD_REQ;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy     = (state != SEQ_IDLE);
  assign mm_read  = (state == SEQ_RD_REQ);
  assign mm_write = (state == SEQ_WR_REQ);
  assign cap_en   = (state == SEQ_RD_WAIT) && mm_rvalid && !is_cfg;
  assign commit   = cap_en && is_last;
  assign rel      = step - STEP_W'(CFG_STEPS);
  assign byte_sel = rel[SEL_W-1:0];

  // R1: an idle start launches a read on the next cycle
  assert_start_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && mm_read));
  // R3: a write only ever begins right after returned read data
  assert_write_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_write && !$past(mm_write)) |-> $past(mm_rvalid));
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_read && mm_write));
  // R6: stalled commands keep their content
  assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_read && mm_waitreq) |=> mm_read);
  assert_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_write && mm_waitreq) |=> (mm_write && $stable(mm_wdata)));
  // R10: a start during a run does not re-latch the mode
  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_q));
endmodule

// File: rtl/errcnt_count_pack.sv
module errcnt_count_pack
  import errcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [SEL_W-1:0]  byte_sel,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              commit,
  output logic [CNT_W-1:0]  count,
  output logic              done
);
  logic [CNT_W-1:0] next_word;

  generate
    for (genvar i = 0; i < CNT_BYTES; i++) begin : g_lane
      logic [DATA_W-1:0] shadow;
      logic              hit;
      assign hit = cap_en && (byte_sel == SEL_W'(i));
      always_ff @(posedge clk) begin
        if (!rst_n) shadow <= '0;
        else if (hit) shadow <= byte_in;
      end
      assign next_word[i*DATA_W +: DATA_W] = hit ? byte_in : shadow;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= commit;
      if (commit) count <= next_word;
    end
  end

  // R9: completion is a single-cycle pulse
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: the result only moves when completion is flagged
  assert_count_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(count));
endmodule

// File: rtl/crc_errcnt_sequencer.sv
module crc_errcnt_sequencer
  import errcnt_pkg::*;
#(
  parameter int PORT_MAP = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              e2e_mode,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  err_count,
  output logic [ADDR_W-1:0] mm_addr,
  output logic              mm_read,
  output logic              mm_write,
  output logic [DATA_W-1:0] mm_wdata,
  input  logic [DATA_W-1:0] mm_rdata,
  input  logic              mm_waitreq,
  input  logic              mm_rvalid
);
  logic [STEP_W-1:0] step;
  logic              mode_q;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] val;
  logic              is_cfg;
  logic              is_last;
  logic              cap_en;
  logic [SEL_W-1:0]  byte_sel;
  logic              commit;

  errcnt_step_table #(.PORT_MAP(PORT_MAP)) u_table (
    .step    (step),
    .e2e     (mode_q),
    .addr    (mm_addr),
    .mask    (mask),
    .val     (val),
    .is_cfg  (is_cfg),
    .is_last (is_last)
  );

  errcnt_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .e2e_mode   (e2e_mode),
    .mask       (mask),
    .val        (val),
    .is_cfg     (is_cfg),
    .is_last    (is_last),
    .mm_rdata   (mm_rdata),
    .mm_waitreq (mm_waitreq),
    .mm_rvalid  (mm_rvalid),
    .step       (step),
    .mode_q     (mode_q),
    .busy       (busy),
    .mm_read    (mm_read),
    .mm_write   (mm_write),
    .mm_wdata   (mm_wdata),
    .cap_en     (cap_en),
    .byte_sel   (byte_sel),
    .commit     (commit)
  );

  errcnt_count_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .byte_sel (byte_sel),
    .byte_in  (mm_rdata),
    .commit   (commit),
    .count    (err_count),
    .done     (done)
  );

  // R6: a stalled read keeps its address
  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_read && mm_waitreq) |=> $stable(mm_addr));
  // R9: completion coincides with the end of the run
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R11: nothing is issued outside a run
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mm_read && !mm_write));
endmodule

// File: tb/test_crc_errcnt_sequencer.sv
`timescale 1ns/1ps

module errcnt_env #(
  parameter int MAP = 0
) (
  input logic clk,
  input logic rst_n
);
  typedef struct {
    bit         wr;
    int         addr;
    logic [7:0] d;
  } op_t;

  logic        start = 1'b0;
  logic        e2e_mode = 1'b0;
  logic        busy, done, mm_read, mm_write;
  logic [31:0] err_count;
  logic [20:0] mm_addr;
  logic [7:0]  mm_wdata;
  logic [7:0]  mm_rdata = 8'h5A;
  logic        mm_waitreq = 1'b0;
  logic        mm_rvalid = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int runs_done = 0;

  int  seed = 1;
  int  style = 0;
  bit  spur_en = 0;

  logic [7:0]  mem [int];
  op_t         q[$];
  bit          exp_busy = 0, exp_done = 0, prev_busy = 0, run_e2e = 0;
  logic [31:0] exp_count = 0, pend_count = 0;
  bit          pend_act = 0;
  int          pend_cnt = 0;
  logic [7:0]  pend_data = 0;
  int          cyc = 0;

  crc_errcnt_sequencer #(.PORT_MAP(MAP)) i_crc_errcnt_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .e2e_mode(e2e_mode),
    .busy(busy), .done(done), .err_count(err_count),
    .mm_addr(mm_addr), .mm_read(mm_read), .mm_write(mm_write),
    .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .mm_waitreq(mm_waitreq), .mm_rvalid(mm_rvalid)
  );

  function automatic int base_of();
    return (MAP == 0) ? 'h340 : (MAP == 1) ? 'h308 : 'h2B4;
  endfunction

  function automatic logic [7:0] init_val(int a, int s);
    if (s == 4) return (a == 'h119) ? 8'hAA : (a == base_of()) ? 8'hE3 : 8'h5C ^ 8'(a);
    return 8'((a * 7 + s * 29) ^ (a >> 3));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s map%0d %s actual=%0h expected=%0h", req, MAP, what, act, exp);
    end
  endtask

  task automatic begin_run(input bit e2e);
    int b;
    int addrs[5];
    logic [7:0] msk[5];
    logic [7:0] vals[5];
    b = base_of();
    addrs = '{'h119, b + 3, b + 2, b + 1, b};
    msk   = '{8'h01, 8'hFF, 8'hFF, 8'hFF, 8'h1F};
    vals  = '{8'h01, e2e ? 8'h03 : 8'h02, e2e ? 8'h02 : 8'h01, 8'h00, 8'h1C};
    mem['h119] = init_val('h119, seed);
    for (int i = 0; i < 8; i++) mem[b + i] = init_val(b + i, seed);
    q.delete();
    for (int i = 0; i < 5; i++) begin
      q.push_back('{0, addrs[i], 8'h00});
      q.push_back('{1, addrs[i], (mem[addrs[i]] & ~msk[i]) | vals[i]});
    end
    for (int i = 0; i < 4; i++) begin
      q.push_back('{0, b + 4 + i, 8'h00});
      pend_count[i*8 +: 8] = mem[b + 4 + i];
    end
    run_e2e = e2e;
  endtask

  always @(negedge clk) begin
    bit fire, nb, nd;
    op_t h;
    cyc++;
    if (!rst_n) begin
      chk(!mm_read && !mm_write && !busy && !done && err_count == 0, "R11", "reset state",
          {mm_read, mm_write, busy, done}, 0);
      mm_waitreq = 1'b0;
      mm_rvalid  = 1'b0;
    end else begin
      chk(busy == exp_busy, "R10", "busy", busy, exp_busy);
      chk(done == exp_done, "R9", "done", done, exp_done);
      chk(err_count == exp_count, spur_en ? "R7" : "R8", "count", err_count, exp_count);
      chk(!(mm_read && mm_write), "R3", "read and write together", {mm_read, mm_write}, 0);
      if (exp_busy && !prev_busy)
        chk(mm_read && mm_addr == 21'h119, "R1", "first command", mm_addr, 'h119);
      if (mm_read || mm_write) begin
        if (q.size() == 0) chk(0, "R3", "unexpected command", mm_addr, 0);
        else begin
          h = q[0];
          chk(mm_write == h.wr, "R3", "command kind", mm_write, h.wr);
          chk(mm_addr == 21'(h.addr), "R2", "address", mm_addr, h.addr);
          if (h.wr) chk(mm_wdata == h.d, run_e2e ? "R5" : "R4", "write data", mm_wdata, h.d);
        end
      end else if (exp_busy && !pend_act && q.size() > 0) begin
        chk(0, "R6", "command missing", 0, q[0].addr);
      end
      prev_busy = exp_busy;

      fire = 0;
      mm_rvalid = 1'b0;
      mm_rdata  = 8'h5A;
      if (pend_act) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          mm_rvalid = 1'b1;
          mm_rdata  = pend_data;
          pend_act  = 0;
          fire      = 1;
        end
      end else if (spur_en && (cyc % 4 == 1)) begin
        mm_rvalid = 1'b1;
        mm_rdata  = 8'hEE;
      end
      case (style)
        1: mm_waitreq = (cyc % 3 == 0);
        2: mm_waitreq = (cyc % 5 != 4);
        default: mm_waitreq = 1'b0;
      endcase
      if ((mm_read || mm_write) && !mm_waitreq && q.size() > 0) begin
        h = q.pop_front();
        if (h.wr) mem[h.addr] = h.d;
        else begin
          pend_act  = 1;
          pend_cnt  = 1 + cyc % 3;
          pend_data = mem[h.addr];
        end
      end
      nb = exp_busy;
      nd = 0;
      if (exp_busy) begin
        if (fire && q.size() == 0) begin
          nb = 0;
          nd = 1;
          exp_count = pend_count;
          runs_done++;
        end
      end else if (start) begin
        nb = 1;
        begin_run(e2e_mode);
      end
      exp_busy = nb;
      exp_done = nd;
    end
  end

  task automatic do_run(input bit e2e, input int s, input int st, input bit sp, input bit poke);
    int target;
    target = runs_done + 1;
    seed = s;
    style = st;
    spur_en = sp;
    @(posedge clk) #1;
    e2e_mode = e2e;
    start = 1'b1;
    @(posedge clk) #1;
    start = 1'b0;
    e2e_mode = ~e2e;
    if (poke) begin
      repeat (6) @(posedge clk);
      #1 start = 1'b1;   // R10: must be ignored mid-run
      @(posedge clk) #1 start = 1'b0;
    end
    wait (runs_done == target);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    wait (rst_n);
    repeat (2) @(posedge clk);
    do_run(0, 1, 0, 0, 0);
    do_run(1, 2, 1, 0, 1);
    do_run(0, 3, 2, 1, 1);
    do_run(1, 4, 2, 1, 0);
    do_run(0, 4, 1, 1, 0);
    finished = 1;
  end
endmodule

module test_crc_errcnt_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  bit   timed_out = 0;

  always #2 clk = ~clk;

  errcnt_env #(.MAP(0)) e_x16 (.clk(clk), .rst_n(rst_n));
  errcnt_env #(.MAP(1)) e_x8  (.clk(clk), .rst_n(rst_n));
  errcnt_env #(.MAP(2)) e_x4  (.clk(clk), .rst_n(rst_n));

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
  end

  initial begin
    int total, bad;
    fork
      wait (e_x16.finished && e_x8.finished && e_x4.finished);
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    total = e_x16.n_chk + e_x8.n_chk + e_x4.n_chk;
    bad   = e_x16.n_fail + e_x8.n_fail + e_x4.n_fail;
    if (timed_out) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=finished");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", total, bad);
    $finish;
  end
endmodule